// File: doc/BRIEF.md
# Free-Running Timer with Lockable Prescaler

The block runs a 16-bit up-counter from the system clock through a divider chosen by a 2-bit select field. Software reaches two 8-bit registers through a single read/write port: an enable (mask) register and an event flag register. The enable register also holds the divider select. The upper four bits of the two registers are paired bit for bit. A flag asks for an interrupt only when the enable bit in the same position is one. All active requests are ORed onto one request line.

The block sets one flag itself, on counter wrap-around. Three more flags are set by single-cycle event inputs from a periodic-tick unit and from a pulse-accumulator unit. Software clears flags by writing ones to them. In normal operation the divider select is protected: it takes one write, and only during a short window after reset. A special-mode input removes that protection so that tests can reprogram the divider freely.

Top module: `tmr_core`

## Requirements
- R1: After reset both registers read 0x00, the count output is 0 and irq is low.
- R2: Divider select code 00, 01, 10 or 11 makes the counter advance once every 1, 4, 8 or 16 clocks. The divider phase runs freely from reset, so with a code set on the first edge the count after N edges (N ≥ 1) is N for code 00 and 1 + floor(N/ratio) for the other codes.
- R3: With special_mode low, a write of the enable register is sampled on some clock edge. If that edge is among the first 64 edges after reset release and no earlier write has been accepted, the write loads the select field.
- R4: With special_mode low, the select field ignores any write after the first accepted one, and any write from the 65th edge onward.
- R5: With special_mode high, every write of the enable register loads the select field, at any time.
- R6: Flag bit 7 sets on the edge where the counter steps from 0xFFFF to 0x0000.
- R7: A write to the flag register (reg_sel = 1) clears each flag written with a one and leaves flags written with a zero unchanged. An event in the same cycle as its clear wins, and the flag stays set.
- R8: The inputs rti_evt, acc_ovf_evt and acc_edge_evt set flag bits 6, 5 and 4 respectively.
- R9: Register layout. Flag register (reg_sel = 1): bits 7:4 are the flags, bits 3:0 read zero. Enable register (reg_sel = 0): bits 7:4 are the enables, bits 3:2 read zero, bits 1:0 are the select. Enable bits 7:4 take every write.
- R10: irq is high exactly when some flag and its enable bit are both one. It stays high until software clears that flag or that enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Lifts the write-once and window limits on the select field |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the flag register |
| wr_data | input | 8 | Write data |
| rti_evt | input | 1 | Periodic-tick event pulse, sets flag 6 |
| acc_ovf_evt | input | 1 | Accumulator overflow pulse, sets flag 5 |
| acc_edge_evt | input | 1 | Accumulator input-edge pulse, sets flag 4 |
| rd_data | output | 8 | Combinational read of the selected register |
| count | output | 16 | Current counter value |
| irq | output | 1 | Combined interrupt request |

## Verification
Every register write, event pulse and counter step takes effect on the clock edge that samples it. A flag, a select value or a new count is therefore visible at the next falling edge. irq and rd_data are combinational from registered state, so they follow in the same half cycle. The bench drives and samples on falling edges and counts edges from reset release. It computes the expected count for each divider code and sample point with integer division. It reads a register only after settling reg_sel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        PSC_DIV1  = 2'b00,
        PSC_DIV4  = 2'b01,
        PSC_DIV8  = 2'b10,
        PSC_DIV16 = 2'b11
    } psc_code_e;

    // index of each flag inside the upper nibble of the flag register
    localparam int FLG_WRAP     = 3;
    localparam int FLG_TICK     = 2;
    localparam int FLG_ACC_OVF  = 1;
    localparam int FLG_ACC_EDGE = 0;

    // low divider bits that must all be ones for a tick
    function automatic logic [3:0] psc_mask(input logic [1:0] code);
        case (psc_code_e'(code))
            PSC_DIV1:  psc_mask = 4'b0000;
            PSC_DIV4:  psc_mask = 4'b0011;
            PSC_DIV8:  psc_mask = 4'b0111;
            default:   psc_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    output logic       tick
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [DIV_W-1:0] sel_mask;

    always_comb begin
        sel_mask   = DIV_W'(psc_mask(code));
        st_d       = st_q;
        st_d.div   = st_q.div + 1'b1;
        tick       = ((st_q.div & sel_mask) == sel_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = st_q.cnt + 1'b1;
        wrap  = tick && (&st_q.cnt);
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int WINDOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       wr_en,
    input  logic       reg_sel,
    input  logic [7:0] wr_data,
    input  logic [3:0] set_evt,
    output logic [3:0] flags,
    output logic [3:0] enables,
    output logic [1:0] presc,
    output logic       locked,
    output logic [7:0] rd_data
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [3:0]       flags;
        logic [3:0]       enables;
        logic [1:0]       presc;
        logic             locked;
        logic [WIN_W-1:0] win;
    } reg_st_t;

    reg_st_t    st_d, st_q;
    logic       win_open;
    logic       presc_ok;
    logic [3:0] clr;
    logic       unused_bits;

    assign unused_bits = ^wr_data[3:2];

    always_comb begin
        st_d     = st_q;
        win_open = (st_q.win < WIN_W'(WINDOW));
        presc_ok = special_mode || (!st_q.locked && win_open);
        if (win_open) st_d.win = st_q.win + 1'b1;

        if (wr_en && !reg_sel) begin
            st_d.enables = wr_data[7:4];
            if (presc_ok) begin
                st_d.presc = wr_data[1:0];
                if (!special_mode) st_d.locked = 1'b1;
            end
        end

        clr        = (wr_en && reg_sel) ? wr_data[7:4] : 4'b0000;
        st_d.flags = (st_q.flags & ~clr) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags   = st_q.flags;
        enables = st_q.enables;
        presc   = st_q.presc;
        locked  = st_q.locked;
        rd_data = reg_sel ? {st_q.flags, 4'b0000}
                          : {st_q.enables, 2'b00, st_q.presc};
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 4,
    parameter int WINDOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [7:0]       wr_data,
    input  logic             rti_evt,
    input  logic             acc_ovf_evt,
    input  logic             acc_edge_evt,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    import tmr_pkg::*;

    logic       tick_w;
    logic       wrap_w;
    logic [1:0] presc_w;
    logic [3:0] flags_w;
    logic [3:0] en_w;
    logic       locked_w;
    logic [3:0] set_w;

    always_comb begin
        set_w               = '0;
        set_w[FLG_WRAP]     = wrap_w;
        set_w[FLG_TICK]     = rti_evt;
        set_w[FLG_ACC_OVF]  = acc_ovf_evt;
        set_w[FLG_ACC_EDGE] = acc_edge_evt;
        irq                 = |(flags_w & en_w);
    end

    tmr_prescale #(.DIV_W(DIV_W)) psc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (presc_w),
        .tick  (tick_w)
    );

    tmr_count #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .count (count),
        .wrap  (wrap_w)
    );

    tmr_regs #(.WINDOW(WINDOW)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_en        (wr_en),
        .reg_sel      (reg_sel),
        .wr_data      (wr_data),
        .set_evt      (set_w),
        .flags        (flags_w),
        .enables      (en_w),
        .presc        (presc_w),
        .locked       (locked_w),
        .rd_data      (rd_data)
    );

endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             special_mode,
    input logic             wr_en,
    input logic             reg_sel,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             tick,
    input logic [3:0]       flags,
    input logic [1:0]       presc,
    input logic             locked
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)); // R2

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> flags[3]); // R6

    AST_PRESC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && !$past(special_mode)) |-> (presc == $past(presc))); // R4

    AST_W1C_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && wr_data[7] && !(tick && (&count))) |=> !flags[3]); // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R10

    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data[3:0] == 4'b0000)); // R9
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_en        (wr_en),
    .reg_sel      (reg_sel),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .count        (count),
    .irq          (irq),
    .tick         (tick_w),
    .flags        (flags_w),
    .presc        (presc_w),
    .locked       (locked_w)
);

// File: tb/tmr_core_tb_top.sv
module tmr_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rti_evt = 1'b0;
    logic        acc_ovf_evt = 1'b0;
    logic        acc_edge_evt = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] count;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_en        (wr_en),
        .reg_sel      (reg_sel),
        .wr_data      (wr_data),
        .rti_evt      (rti_evt),
        .acc_ovf_evt  (acc_ovf_evt),
        .acc_edge_evt (acc_edge_evt),
        .rd_data      (rd_data),
        .count        (count),
        .irq          (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; rti_evt = 1'b0; acc_ovf_evt = 1'b0; acc_edge_evt = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        do_reset();
        // R1 reset state
        rd(1'b0, v); check("R1 enable reg", v, 8'h00);
        rd(1'b1, v); check("R1 flag reg", v, 8'h00);
        check("R1 count", count, 0);
        check("R1 irq", irq, 0);

        // R2 sweep over every divider code
        for (int code = 0; code < 4; code++) begin
            int r;
            r = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
            do_reset();
            wr(1'b0, 8'(code));
            for (int n = 1; n <= 70; n++) begin
                check("R2 count", count, (r == 1) ? n : 1 + n / r);
                step(1);
            end
        end

        // R3 write on the 64th edge is accepted
        do_reset();
        step(63);
        wr(1'b0, 8'h03);
        rd(1'b0, v); check("R3 select at edge 64", v, 8'h03);

        // R4 write on the 65th edge is ignored, enables still taken (R9)
        do_reset();
        step(64);
        wr(1'b0, 8'hA2);
        rd(1'b0, v); check("R4 late select ignored / R9 enables", v, 8'hA0);

        // R4 second write ignored
        do_reset();
        wr(1'b0, 8'h01);
        step(3);
        wr(1'b0, 8'h02);
        rd(1'b0, v); check("R4 second write ignored", v, 8'h01);

        // R5 special mode rewrites any time; R9 bits 3:2 read zero
        do_reset();
        special_mode = 1'b1;
        step(100);
        wr(1'b0, 8'h02);
        rd(1'b0, v); check("R5 special rewrite 1", v, 8'h02);
        wr(1'b0, 8'hFF);
        rd(1'b0, v); check("R5 special rewrite 2 / R9 layout", v, 8'hF3);
        special_mode = 1'b0;

        // R8 events, R10 irq gating, R7 clear semantics
        do_reset();
        rti_evt = 1'b1; step(1); rti_evt = 1'b0;
        rd(1'b1, v); check("R8 tick event sets bit 6", v, 8'h40);
        check("R10 irq masked", irq, 0);
        wr(1'b0, 8'h40);
        check("R10 irq enabled", irq, 1);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R7 zero write keeps flag", v, 8'h40);
        check("R10 irq held", irq, 1);
        rti_evt = 1'b1; wr(1'b1, 8'h40); rti_evt = 1'b0;
        rd(1'b1, v); check("R7 set wins over clear", v, 8'h40);
        wr(1'b1, 8'h40);
        rd(1'b1, v); check("R7 one clears", v, 8'h00);
        check("R10 irq drops", irq, 0);
        acc_ovf_evt = 1'b1; step(1); acc_ovf_evt = 1'b0;
        rd(1'b1, v); check("R8 acc overflow sets bit 5", v, 8'h20);
        acc_edge_evt = 1'b1; step(1); acc_edge_evt = 1'b0;
        rd(1'b1, v); check("R8 acc edge sets bit 4", v, 8'h30);
        check("R10 irq off for unenabled", irq, 0);
        wr(1'b0, 8'h10);
        check("R10 irq edge enabled", irq, 1);
        wr(1'b0, 8'h00);
        check("R10 irq enable cleared", irq, 0);
        wr(1'b1, 8'h20);
        rd(1'b1, v); check("R7 clears only written bit", v, 8'h10);

        // R6 wrap flag at divide-by-1
        do_reset();
        wr(1'b0, 8'h80);
        step(65534);
        check("R6 count at top", count, 16'hFFFF);
        rd(1'b1, v); check("R6 no flag before wrap", v, 8'h00);
        step(1);
        check("R6 count wrapped", count, 0);
        rd(1'b1, v); check("R6 wrap flag", v, 8'h80);
        check("R10 irq on wrap", irq, 1);
        wr(1'b1, 8'h80);
        rd(1'b1, v); check("R7 wrap flag cleared", v, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule